// File: doc/BRIEF.md
# RTC Event Output Waveform Generator

This block turns real-time-clock event strobes into a shaped signal for an output pad. Two single-cycle strobes arrive in the RTC clock domain: a compare-match strobe and a one-second tick. A memory-mapped control register decides three things: which strobe is used, whether the output is a one-clock pulse or a held level, and which logic level counts as active. It also gates the pad driver. The block drives the pad value and a separate pad-enable signal. When the enable is low, the pad buffer outside the block floats the pin.

In level mode, the selected event sets a status flag, and the output stays active for as long as the flag is set. Software clears the flag by reading the register, and that same read releases the output. The register port has no back-pressure. A write or a read strobe completes in the cycle it is presented. Read data is a combinational function of the address and the current register state.

Top module: `rtc_evout`

## Requirements
- R1: After reset the control register (byte offset 0x08) reads 0x0000_0F00, `evt_oe` is 0 and `evt_out` is 0.
- R2: Bits 0, 2 to 6, 8 to 11 and 16 to 19 are read/write storage. Bit 1, bit 7, bits 12 to 15 and bits 21 to 31 read as 0. Any other address reads 0, and writes to other addresses change nothing.
- R3: Bit 17 selects the event source: 0 selects `cmp_stb` and 1 selects `sec_stb`. The other strobe has no effect on the output.
- R4: Pulse mode (bit 18 = 0): each selected strobe makes the output active for exactly the next clock cycle. Strobes on consecutive cycles keep it active without a gap. The flag is never set in this mode.
- R5: Bit 19 = 0 means the active level is high, and bit 19 = 1 means it is low. The output is registered, so a polarity write changes `evt_out` one clock after the register takes the new value.
- R6: Bit 16 enables the output. `evt_oe` follows it one clock after the register update. While bit 16 is 0, strobes neither activate the output nor set the flag.
- R7: Level mode (bit 18 = 1): a selected strobe sets the read-only flag at bit 20 on the next edge, and the output stays active while the flag is set.
- R8: A read of the register clears the flag at that edge, and the output goes inactive in the same edge. If a selected strobe arrives in the same cycle as the read, the set wins and the flag stays set.
- R9: Writes to bit 20 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | RTC clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (triggers read-to-clear) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data (combinational) |
| cmp_stb | input | 1 | Compare-match event strobe |
| sec_stb | input | 1 | One-second tick strobe |
| evt_out | output | 1 | Pad value, polarity applied |
| evt_oe | output | 1 | Pad drive enable; 0 floats the pin |

## Verification
A strobe sampled at edge k shows on `evt_out` and in the flag bit of `bus_rdata` right after edge k. A register write at edge k moves `evt_oe` and the polarity-adjusted `evt_out` at edge k+1. A read at edge k clears the flag and the output at edge k itself. The bench drives every input on the falling edge and samples on the falling edge that follows the edge where each result is due. It captures read data just after it presents a read strobe, before the clearing edge. Hold and release are therefore checked on exact cycles, and so is the same-cycle read and event.

// File: rtl/rtcevo_pkg.sv
package rtcevo_pkg;
  localparam int DATA_W = 32;
  localparam int B_EN   = 16;
  localparam int B_SRC  = 17;
  localparam int B_LVL  = 18;
  localparam int B_POL  = 19;
  localparam int B_FLG  = 20;
  localparam logic [DATA_W-1:0] RW_MASK = 32'h000F_0F7D;
  localparam logic [DATA_W-1:0] RST_VAL = 32'h0000_0F00;

  typedef struct packed {
    logic en;
    logic src_sec;
    logic level;
    logic pol_lo;
  } outcfg_t;
endpackage

// File: rtl/rtcevo_regs.sv
module rtcevo_regs
  import rtcevo_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter logic [ADDR_W-1:0] CTRL_OFFS = 8'h08
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [DATA_W-1:0] wdata,
  input  logic              ev_set,
  output logic [DATA_W-1:0] rdata,
  output outcfg_t           cfg,
  output logic              flag_nxt
);
  localparam logic [DATA_W-1:0] FLG_BIT = DATA_W'(1) << B_FLG;

  logic [DATA_W-1:0] store_q;
  logic              flag_q;
  logic              hit, rd_hit;

  assign hit    = (addr == CTRL_OFFS);
  assign rd_hit = hit & rd_en;

  // flag set beats read-to-clear
  assign flag_nxt = ev_set | (flag_q & ~rd_hit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      store_q <= RST_VAL;
      flag_q  <= 1'b0;
    end else begin
      if (wr_en && hit) store_q <= wdata & RW_MASK;
      flag_q <= flag_nxt;
    end
  end

  assign cfg.en      = store_q[B_EN];
  assign cfg.src_sec = store_q[B_SRC];
  assign cfg.level   = store_q[B_LVL];
  assign cfg.pol_lo  = store_q[B_POL];

  assign rdata = hit ? (store_q | (flag_q ? FLG_BIT : '0)) : '0;

  // R8
  rd_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_hit && !ev_set) |=> !flag_q);
  // R8
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_set |=> flag_q);
  // R4
  flag_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_q) |-> $past(cfg.level));
  // R2
  rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rdata & ~(RW_MASK | FLG_BIT)) == '0);
endmodule

// File: rtl/rtcevo_shaper.sv
module rtcevo_shaper
  import rtcevo_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  outcfg_t cfg,
  input  logic    cmp_stb,
  input  logic    sec_stb,
  input  logic    flag_nxt,
  output logic    ev_set,
  output logic    evt_out,
  output logic    evt_oe
);
  logic sel_ev, active_nxt;
  logic out_q, oe_q;

  assign sel_ev     = cfg.src_sec ? sec_stb : cmp_stb;
  assign ev_set     = cfg.en & cfg.level & sel_ev;
  assign active_nxt = cfg.en & (cfg.level ? flag_nxt : sel_ev);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q <= 1'b0;
      oe_q  <= 1'b0;
    end else begin
      out_q <= active_nxt ^ cfg.pol_lo;
      oe_q  <= cfg.en;
    end
  end

  assign evt_out = out_q;
  assign evt_oe  = oe_q;

  // R6
  oe_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt_oe == $past(cfg.en));
  // R4
  pulse_act_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg.en && !cfg.level && sel_ev) |=> (evt_out != $past(cfg.pol_lo)));
  // R7
  level_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg.en && cfg.level && flag_nxt) |=> (evt_out != $past(cfg.pol_lo)));
endmodule

// File: rtl/rtc_evout.sv
module rtc_evout
  import rtcevo_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] CTRL_OFFS = 8'h08
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic              cmp_stb,
  input  logic              sec_stb,
  output logic              evt_out,
  output logic              evt_oe
);
  outcfg_t cfg;
  logic    ev_set, flag_nxt;

  rtcevo_regs #(.ADDR_W(ADDR_W), .CTRL_OFFS(CTRL_OFFS)) u_regs (
    .clk(clk), .rst_n(rst_n), .addr(bus_addr), .wr_en(bus_wr),
    .rd_en(bus_rd), .wdata(bus_wdata), .ev_set(ev_set),
    .rdata(bus_rdata), .cfg(cfg), .flag_nxt(flag_nxt)
  );

  rtcevo_shaper u_shape (
    .clk(clk), .rst_n(rst_n), .cfg(cfg), .cmp_stb(cmp_stb),
    .sec_stb(sec_stb), .flag_nxt(flag_nxt), .ev_set(ev_set),
    .evt_out(evt_out), .evt_oe(evt_oe)
  );
endmodule

// File: tb/sim_rtc_evout.sv
`timescale 1ns/1ps
module sim_rtc_evout;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        cmp_stb = 1'b0, sec_stb = 1'b0;
  logic        evt_out, evt_oe;
  int          total = 0, bad = 0;
  bit          done = 1'b0;

  always #2 clk = ~clk;

  rtc_evout u0 (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .cmp_stb(cmp_stb), .sec_stb(sec_stb), .evt_out(evt_out), .evt_oe(evt_oe)
  );

  typedef struct packed {
    logic [31:0] cfg;
    logic        cmp;
    logic        sec;
    logic        eout;
    logic        eoe;
    logic        eflg;
  } vec_t;

  // cfg bits: 16 enable, 17 source(1=sec), 18 level, 19 active-low
  localparam vec_t VEC [9] = '{
    '{32'h0001_0000, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0}, // R3 R4 cmp pulse
    '{32'h0001_0000, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0}, // R3 sec ignored
    '{32'h0003_0000, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0}, // R3 sec pulse
    '{32'h0009_0000, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0}, // R5 active low
    '{32'h0009_0000, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0}, // R5 idle low-active
    '{32'h0000_0000, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0}, // R6 disabled
    '{32'h0005_0000, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1}, // R7 level cmp
    '{32'h000F_0000, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1}, // R7 level sec low
    '{32'h0004_0000, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0}  // R6 level disabled
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_rd = 1'b1;
    #1 d = bus_rdata;
    @(negedge clk); bus_rd = 1'b0;
  endtask

  task automatic stb(input logic c, input logic s);
    @(negedge clk); cmp_stb = c; sec_stb = s;
    @(negedge clk); cmp_stb = 1'b0; sec_stb = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog act=hung exp=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 oe", 32'(evt_oe), 32'h0);
    chk("R1 out", 32'(evt_out), 32'h0);
    rd(8'h08, d); chk("R1 reset value", d, 32'h0000_0F00);

    foreach (VEC[i]) begin
      wr(8'h08, VEC[i].cfg);
      @(negedge clk);
      stb(VEC[i].cmp, VEC[i].sec);
      chk($sformatf("R3-R7 vec%0d out", i), 32'(evt_out), 32'(VEC[i].eout));
      chk($sformatf("R6 vec%0d oe", i), 32'(evt_oe), 32'(VEC[i].eoe));
      rd(8'h08, d);
      chk($sformatf("R4 R7 vec%0d flag", i), 32'(d[20]), 32'(VEC[i].eflg));
    end

    // R2 R9: storage mask, reserved and flag bit not writable
    wr(8'h08, 32'hFFFF_FFFF);
    rd(8'h08, d); chk("R2 R9 readback", d, 32'h000F_0F7D);
    wr(8'h08, 32'h0);
    wr(8'h0C, 32'hFFFF_FFFF);
    rd(8'h08, d); chk("R2 other addr write ignored", d, 32'h0);
    rd(8'h0C, d); chk("R2 other addr reads zero", d, 32'h0);

    // R7 R8: level hold and read release
    wr(8'h08, 32'h0005_0000);
    @(negedge clk);
    stb(1'b1, 1'b0);
    repeat (4) @(negedge clk);
    chk("R7 held", 32'(evt_out), 32'h1);
    rd(8'h08, d);
    chk("R7 flag read", 32'(d[20]), 32'h1);
    chk("R8 released", 32'(evt_out), 32'h0);

    // R8: event and read in the same cycle
    stb(1'b1, 1'b0);
    @(negedge clk); bus_addr = 8'h08; bus_rd = 1'b1; cmp_stb = 1'b1;
    @(negedge clk); bus_rd = 1'b0; cmp_stb = 1'b0;
    chk("R8 set wins out", 32'(evt_out), 32'h1);
    rd(8'h08, d);
    chk("R8 set wins flag", 32'(d[20]), 32'h1);
    chk("R8 cleared after", 32'(evt_out), 32'h0);

    // R4: back-to-back pulses
    wr(8'h08, 32'h0001_0000);
    @(negedge clk);
    @(negedge clk); cmp_stb = 1'b1;
    @(negedge clk); chk("R4 b2b first", 32'(evt_out), 32'h1);
    @(negedge clk); cmp_stb = 1'b0; chk("R4 b2b second", 32'(evt_out), 32'h1);
    @(negedge clk); chk("R4 pulse ends", 32'(evt_out), 32'h0);

    // R5: polarity change one clock after the register update
    wr(8'h08, 32'h0009_0000);
    chk("R5 not yet", 32'(evt_out), 32'h0);
    @(negedge clk);
    chk("R5 applied", 32'(evt_out), 32'h1);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule